// File: doc/BRIEF.md
# Memory region access firewall

This block sits in front of one memory range and decides, for every incoming transaction, whether it may proceed. Software programs a small set of base regions through a 32-bit register bus. Each region carries an enable, a secure-only flag, an encryption-request flag, a per-compartment privilege mask and separate per-compartment read and write enable masks, plus inclusive start and end bounds. The bounds are compared only on a configurable field of offset bits, so regions are aligned to a granule of 2^GRAN_LSB bytes.

A transaction presents an address, a direction, a secure flag, a privileged flag and a 3-bit compartment ID. One cycle later the block answers with a grant or a denial and a reason code. The first denial is logged (offset plus a status word) until software clears it with a write-one-to-clear register. Later denials only raise an overflow flag. A sticky global lock freezes the whole configuration; configuration writes that are refused set a configuration-error flag.

Top module: `mem_region_filter`

## Requirements
- R1: After reset the control, status, fault-info and fault-offset registers and every region register read 0, and no region is enabled.
- R2: Region n (n from 1 to N_RGN) owns a group at byte offset 0x40*n: config at +0x0 (bit 0 enable, bit 8 secure, bit 15 encrypt, bits 23:16 privilege-required per compartment), start at +0x4, end at +0x8, compartment access at +0xC (bits 7:0 read enable per compartment, bits 23:16 write enable with bit c+16 for compartment c). Unlisted bits read 0; start and end keep only offset bits GRAN_LSB+FIELD_W-1:GRAN_LSB.
- R3: The offset is the address minus MEM_BASE; a region matches when it is enabled and start <= offset field <= end (end inclusive). A transaction that matches no region is denied with reason 1.
- R4: When several enabled regions match, the lowest-numbered one alone decides the outcome.
- R5: A non-secure transaction to a secure region is denied with reason 2; secure transactions may use non-secure regions.
- R6: A non-privileged transaction from compartment c is denied with reason 3 when the decisive region has privilege bit c set.
- R7: A read from compartment c needs read-enable bit c, a write needs write-enable bit c+16; otherwise it is denied with reason 4. A granted transaction reports reason 0.
- R8: resp_valid is req_valid delayed by exactly one clock, and resp_grant and resp_reason belong to that request.
- R9: Writing 1 to control bit 0 (0x00) sets the lock; it then stays set until reset, and all later writes to the control register or any region register are ignored.
- R10: A config write with the encrypt bit set and the secure bit clear is ignored; such a write, and any write refused by the lock, sets status bit 0.
- R11: A denial sets status bit 1 (0x08) and, if bit 1 was clear, captures the offset at 0x24 and a status word at 0x20 (bit 0 write, bit 1 secure, bit 2 privileged, bits 6:4 compartment, bits 10:8 reason); a denial while bit 1 is set changes neither and sets status bit 2.
- R12: Writing ones to bits 2:0 of the clear register at 0x0C clears the matching status bits; zeros leave them unchanged; clearing is allowed while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| req_valid | input | 1 | Transaction present |
| req_addr | input | ADDR_W | Transaction address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Transaction is secure |
| req_priv | input | 1 | Transaction is privileged |
| req_cid | input | 3 | Compartment ID |
| resp_valid | output | 1 | Verdict present (one cycle after req_valid) |
| resp_grant | output | 1 | Transaction granted |
| resp_reason | output | 3 | 0 grant, 1 no region, 2 security, 3 privilege, 4 permission |

## Verification
The assertions assume the register bus and the transaction port are never both used in a way that makes a verdict depend on a configuration write landing on the same edge, and that reset is held for at least one clock before traffic starts. The stimulus keeps bus writes and transactions in separate cycles, driven on the falling edge, and draws random offsets only from the low 20 bits so every offset field value occurs. Random configuration words are unrestricted, so refused encryption settings and lock rejections arise naturally alongside the directed cases.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    localparam int CID_N = 8;
    localparam int CID_W = 3;

    localparam logic [11:0] A_CTRL    = 12'h000;
    localparam logic [11:0] A_STAT    = 12'h008;
    localparam logic [11:0] A_CLR     = 12'h00C;
    localparam logic [11:0] A_ERRINFO = 12'h020;
    localparam logic [11:0] A_ERROFF  = 12'h024;

    localparam logic [5:0] SUB_CFG = 6'h00;
    localparam logic [5:0] SUB_LO  = 6'h04;
    localparam logic [5:0] SUB_HI  = 6'h08;
    localparam logic [5:0] SUB_CID = 6'h0C;

    typedef enum logic [2:0] {
        V_GRANT      = 3'd0,
        V_NO_REGION  = 3'd1,
        V_SECURITY   = 3'd2,
        V_PRIVILEGE  = 3'd3,
        V_PERMISSION = 3'd4
    } verdict_e;

    typedef struct packed {
        logic             en;
        logic             sec;
        logic             enc;
        logic [CID_N-1:0] priv;
        logic [CID_N-1:0] rd_en;
        logic [CID_N-1:0] wr_en;
    } rgn_attr_t;

    typedef struct packed {
        logic             write;
        logic             secure;
        logic             privileged;
        logic [CID_W-1:0] cid;
    } txn_t;

    function automatic verdict_e judge(logic hit, rgn_attr_t a, txn_t t);
        if (!hit)
            return V_NO_REGION;
        if (a.sec && !t.secure)
            return V_SECURITY;
        if (a.priv[t.cid] && !t.privileged)
            return V_PRIVILEGE;
        if (t.write ? !a.wr_en[t.cid] : !a.rd_en[t.cid])
            return V_PERMISSION;
        return V_GRANT;
    endfunction

    function automatic logic [31:0] cfg_word(rgn_attr_t a);
        return {8'h00, a.priv, a.enc, 6'h00, a.sec, 7'h00, a.en};
    endfunction

    function automatic logic [31:0] cid_word(rgn_attr_t a);
        return {8'h00, a.wr_en, 8'h00, a.rd_en};
    endfunction

    function automatic logic [15:0] fault_word(verdict_e v, txn_t t);
        return {5'h00, v, 1'b0, t.cid, 1'b0, t.privileged, t.secure, t.write};
    endfunction

endpackage

// File: rtl/mrf_regs.sv
module mrf_regs
    import mrf_pkg::*;
#(
    parameter int N_RGN    = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 12,
    parameter int FIELD_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_we,
    input  logic [11:0]                     bus_addr,
    input  logic [31:0]                     bus_wdata,
    input  logic [2:0]                      flags,
    input  logic [15:0]                     err_info,
    input  logic [ADDR_W-1:0]               err_off,
    output logic [31:0]                     bus_rdata,
    output rgn_attr_t [N_RGN-1:0]           attr,
    output logic [N_RGN-1:0][FIELD_W-1:0]   lo,
    output logic [N_RGN-1:0][FIELD_W-1:0]   hi,
    output logic                            locked,
    output logic                            cfg_err,
    output logic [2:0]                      clr_mask
);
    localparam int FMSB = GRAN_LSB + FIELD_W - 1;

    logic [5:0]       grp;
    logic [5:0]       sub;
    logic             ctrl_hit;
    logic [N_RGN-1:0] grp_hit;
    logic             bad_enc;
    logic             wr_ok;
    logic             unused_wdata;

    assign grp          = bus_addr[11:6];
    assign sub          = bus_addr[5:0];
    assign ctrl_hit     = (bus_addr == A_CTRL);
    assign bad_enc      = bus_wdata[15] && !bus_wdata[8];
    assign wr_ok        = bus_we && !locked;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        if (locked)
            cfg_err = bus_we && (ctrl_hit || (|grp_hit));
        else
            cfg_err = bus_we && (|grp_hit) && (sub == SUB_CFG) && bad_enc;
    end

    assign clr_mask = (bus_we && bus_addr == A_CLR) ? bus_wdata[2:0] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (wr_ok && ctrl_hit && bus_wdata[0])
            locked <= 1'b1;
    end

    for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
        rgn_attr_t          a_q;
        logic [FIELD_W-1:0] lo_q;
        logic [FIELD_W-1:0] hi_q;

        assign grp_hit[g] = (grp == 6'(g + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q  <= '0;
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_ok && grp_hit[g]) begin
                case (sub)
                    SUB_CFG: if (!bad_enc) begin
                        a_q.en   <= bus_wdata[0];
                        a_q.sec  <= bus_wdata[8];
                        a_q.enc  <= bus_wdata[15];
                        a_q.priv <= bus_wdata[23:16];
                    end
                    SUB_LO:  lo_q <= bus_wdata[FMSB:GRAN_LSB];
                    SUB_HI:  hi_q <= bus_wdata[FMSB:GRAN_LSB];
                    SUB_CID: begin
                        a_q.rd_en <= bus_wdata[7:0];
                        a_q.wr_en <= bus_wdata[23:16];
                    end
                    default: ;
                endcase
            end
        end

        assign attr[g] = a_q;
        assign lo[g]   = lo_q;
        assign hi[g]   = hi_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:    bus_rdata = {31'h0, locked};
            A_STAT:    bus_rdata = {29'h0, flags};
            A_ERRINFO: bus_rdata = {16'h0, err_info};
            A_ERROFF:  bus_rdata = 32'(err_off);
            default: begin
                for (int g = 0; g < N_RGN; g++) begin
                    if (grp_hit[g]) begin
                        case (sub)
                            SUB_CFG: bus_rdata = cfg_word(attr[g]);
                            SUB_LO:  bus_rdata = 32'(lo[g]) << GRAN_LSB;
                            SUB_HI:  bus_rdata = 32'(hi[g]) << GRAN_LSB;
                            SUB_CID: bus_rdata = cid_word(attr[g]);
                            default: bus_rdata = '0;
                        endcase
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/mrf_match.sv
module mrf_match
    import mrf_pkg::*;
#(
    parameter int N_RGN   = 4,
    parameter int FIELD_W = 8
) (
    input  rgn_attr_t [N_RGN-1:0]          attr,
    input  logic [N_RGN-1:0][FIELD_W-1:0]  lo,
    input  logic [N_RGN-1:0][FIELD_W-1:0]  hi,
    input  logic [FIELD_W-1:0]             field,
    output logic                           hit,
    output rgn_attr_t                      sel
);
    logic [N_RGN-1:0] cand;

    for (genvar g = 0; g < N_RGN; g++) begin : g_cmp
        assign cand[g] = attr[g].en && (field >= lo[g]) && (field <= hi[g]);
    end

    always_comb begin
        sel = '0;
        for (int g = N_RGN - 1; g >= 0; g--) begin
            if (cand[g])
                sel = attr[g];
        end
    end

    assign hit = |cand;

endmodule

// File: rtl/mrf_faults.sv
module mrf_faults #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deny,
    input  logic [15:0]       info,
    input  logic [ADDR_W-1:0] offset,
    input  logic              cfg_err,
    input  logic [2:0]        clr_mask,
    output logic [2:0]        flags,
    output logic [15:0]       err_info,
    output logic [ADDR_W-1:0] err_off
);
    logic [2:0] after_clr;
    logic       capture;

    assign after_clr = flags & ~clr_mask;
    assign capture   = deny && !after_clr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            err_info <= '0;
            err_off  <= '0;
        end else begin
            flags[0] <= after_clr[0] | cfg_err;
            flags[1] <= after_clr[1] | deny;
            flags[2] <= after_clr[2] | (deny && after_clr[1]);
            if (capture) begin
                err_info <= info;
                err_off  <= offset;
            end
        end
    end

endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter
    import mrf_pkg::*;
#(
    parameter int                N_RGN    = 4,
    parameter int                ADDR_W   = 32,
    parameter int                GRAN_LSB = 12,
    parameter int                FIELD_W  = 8,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic [2:0]        req_cid,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic [2:0]        resp_reason
);
    rgn_attr_t [N_RGN-1:0]          attr;
    logic [N_RGN-1:0][FIELD_W-1:0]  lo;
    logic [N_RGN-1:0][FIELD_W-1:0]  hi;
    logic                           cfg_locked;
    logic                           cfg_err;
    logic [2:0]                     clr_mask;
    logic [2:0]                     flags;
    logic [15:0]                    err_info;
    logic [ADDR_W-1:0]              err_off;
    logic [ADDR_W-1:0]              offset;
    logic [FIELD_W-1:0]             field;
    logic                           m_hit;
    rgn_attr_t                      m_attr;
    txn_t                           txn;
    verdict_e                       verdict;
    logic                           deny;

    assign offset = req_addr - MEM_BASE;
    assign field  = FIELD_W'(offset >> GRAN_LSB);
    assign txn    = '{write: req_write, secure: req_secure,
                      privileged: req_priv, cid: req_cid};

    mrf_regs #(
        .N_RGN(N_RGN), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .FIELD_W(FIELD_W)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flags(flags), .err_info(err_info),
        .err_off(err_off), .bus_rdata(bus_rdata), .attr(attr), .lo(lo),
        .hi(hi), .locked(cfg_locked), .cfg_err(cfg_err), .clr_mask(clr_mask)
    );

    mrf_match #(
        .N_RGN(N_RGN), .FIELD_W(FIELD_W)
    ) u_match (
        .attr(attr), .lo(lo), .hi(hi), .field(field), .hit(m_hit), .sel(m_attr)
    );

    assign verdict = judge(m_hit, m_attr, txn);
    assign deny    = req_valid && (verdict != V_GRANT);

    mrf_faults #(
        .ADDR_W(ADDR_W)
    ) u_faults (
        .clk(clk), .rst(rst), .deny(deny), .info(fault_word(verdict, txn)),
        .offset(offset), .cfg_err(cfg_err), .clr_mask(clr_mask),
        .flags(flags), .err_info(err_info), .err_off(err_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_grant  <= 1'b0;
            resp_reason <= V_GRANT;
        end else begin
            resp_valid  <= req_valid;
            resp_grant  <= req_valid && (verdict == V_GRANT);
            resp_reason <= req_valid ? verdict : V_GRANT;
        end
    end

endmodule

// File: rtl/mrf_checker.sv
module mrf_checker
    import mrf_pkg::*;
#(
    parameter int N_RGN  = 4,
    parameter int ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_secure,
    input logic                  req_priv,
    input logic [2:0]            req_cid,
    input logic                  resp_valid,
    input logic                  resp_grant,
    input logic                  locked,
    input logic                  hit,
    input rgn_attr_t             sel,
    input rgn_attr_t [N_RGN-1:0] attr_all,
    input logic [2:0]            flags,
    input logic [2:0]            clr_mask,
    input logic [ADDR_W-1:0]     err_off
);
    logic [N_RGN-1:0] enc_bad;

    always_comb begin
        for (int g = 0; g < N_RGN; g++)
            enc_bad[g] = attr_all[g].enc && !attr_all[g].sec;
    end

    AST_RESP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);                                      // R8
    AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);                                    // R8
    AST_NOHIT_DENIED: assert property (@(posedge clk) disable iff (rst)
        req_valid && !hit |=> !resp_grant);                             // R3
    AST_SEC_DENIED: assert property (@(posedge clk) disable iff (rst)
        req_valid && hit && sel.sec && !req_secure |=> !resp_grant);    // R5
    AST_PRIV_DENIED: assert property (@(posedge clk) disable iff (rst)
        req_valid && hit && sel.priv[req_cid] && !req_priv |=> !resp_grant); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);                                             // R9
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(attr_all));                                  // R9
    AST_ENC_NEEDS_SEC: assert property (@(posedge clk) disable iff (rst)
        enc_bad == '0);                                                 // R10
    AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_grant |-> flags[1]);                        // R11
    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
        flags[1] && !clr_mask[1] |=> $stable(err_off));                 // R11

endmodule

bind mem_region_filter mrf_checker #(.N_RGN(N_RGN), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_secure(req_secure),
    .req_priv(req_priv), .req_cid(req_cid), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .locked(cfg_locked), .hit(m_hit), .sel(m_attr),
    .attr_all(attr), .flags(flags), .clr_mask(clr_mask), .err_off(err_off)
);

// File: tb/sim_mem_region_filter.sv
`timescale 1ns/1ps
module sim_mem_region_filter;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic        req_priv = 1'b0;
    logic [2:0]  req_cid = '0;
    logic        resp_valid;
    logic        resp_grant;
    logic [2:0]  resp_reason;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the configuration and fault log
    logic [31:0] m_cfg [4];
    logic [31:0] m_lo  [4];
    logic [31:0] m_hi  [4];
    logic [31:0] m_cid [4];
    bit          m_lock;
    logic [2:0]  m_flags;
    logic [31:0] m_info;
    logic [31:0] m_off;

    always #2.5 clk = ~clk;

    mem_region_filter u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
        .req_priv(req_priv), .req_cid(req_cid), .resp_valid(resp_valid),
        .resp_grant(resp_grant), .resp_reason(resp_reason)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        int g;
        if (a == 12'h000) begin
            if (m_lock) m_flags[0] = 1'b1;
            else if (d[0]) m_lock = 1'b1;
        end else if (a == 12'h00C) begin
            m_flags = m_flags & ~d[2:0];
        end else if (a[11:6] >= 1 && a[11:6] <= 4) begin
            g = int'(a[11:6]) - 1;
            if (m_lock) m_flags[0] = 1'b1;
            else case (a[5:0])
                6'h00: if (d[15] && !d[8]) m_flags[0] = 1'b1;
                       else m_cfg[g] = d & 32'h00FF_8101;
                6'h04: m_lo[g]  = (d >> 12) & 32'hFF;
                6'h08: m_hi[g]  = (d >> 12) & 32'hFF;
                6'h0C: m_cid[g] = d & 32'h00FF_00FF;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        int g;
        case (a)
            12'h000: return {31'h0, m_lock};
            12'h008: return {29'h0, m_flags};
            12'h020: return m_info;
            12'h024: return m_off;
            default: ;
        endcase
        if (a[11:6] >= 1 && a[11:6] <= 4) begin
            g = int'(a[11:6]) - 1;
            case (a[5:0])
                6'h00: return m_cfg[g];
                6'h04: return m_lo[g] << 12;
                6'h08: return m_hi[g] << 12;
                6'h0C: return m_cid[g];
                default: ;
            endcase
        end
        return 32'h0;
    endfunction

    function automatic int exp_verdict(logic [31:0] off, bit w, bit s, bit p, int cid);
        logic [31:0] f;
        f = (off >> 12) & 32'hFF;
        for (int g = 0; g < 4; g++) begin
            if (m_cfg[g][0] && f >= m_lo[g] && f <= m_hi[g]) begin
                if (m_cfg[g][8] && !s) return 2;
                if (m_cfg[g][16+cid] && !p) return 3;
                if (w ? !m_cid[g][16+cid] : !m_cid[g][cid]) return 4;
                return 0;
            end
        end
        return 1;
    endfunction

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_chk(string tag, logic [11:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    task automatic do_req(string tag, logic [31:0] off, bit w, bit s, bit p, int cid);
        int v;
        v = exp_verdict(off, w, s, p, cid);
        @(negedge clk);
        req_valid = 1'b1; req_addr = BASE + off; req_write = w;
        req_secure = s; req_priv = p; req_cid = 3'(cid);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, {31'h0, resp_valid}, 32'd1);
        chk({tag, " grant"}, {31'h0, resp_grant}, {31'h0, v == 0});
        chk({tag, " reason"}, {29'h0, resp_reason}, 32'(v));
        if (v != 0) begin
            if (!m_flags[1]) begin
                m_flags[1] = 1'b1;
                m_off  = off;
                m_info = {21'h0, 3'(v), 1'b0, 3'(cid), 1'b0, p, s, w};
            end else begin
                m_flags[2] = 1'b1;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 4; g++) begin
            m_cfg[g] = 0; m_lo[g] = 0; m_hi[g] = 0; m_cid[g] = 0;
        end
        m_lock = 0; m_flags = 0; m_info = 0; m_off = 0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_chk("R1 ctrl", 12'h000);
        read_chk("R1 status", 12'h008);
        read_chk("R1 info", 12'h020);
        read_chk("R1 offset", 12'h024);
        read_chk("R1 rgn1 cfg", 12'h040);
        read_chk("R1 rgn4 cid", 12'h10C);
        @(negedge clk);
        chk("R8 idle resp", {31'h0, resp_valid}, 32'd0);

        // R3 empty configuration denies
        do_req("R3 empty", 32'h0000_5000, 1'b0, 1'b1, 1'b1, 0);
        read_chk("R11 status after deny", 12'h008);
        bus_write(12'h00C, 32'h7);
        read_chk("R12 cleared", 12'h008);

        // R2 region 1: offsets 0x10000..0x1FFFF, all compartments rw
        bus_write(12'h044, 32'hFFF1_0ABC);
        read_chk("R2 start masked", 12'h044);
        chk("R2 start value", model_read(12'h044), 32'h0001_0000);
        bus_write(12'h048, 32'h0001_F000);
        bus_write(12'h04C, 32'hFFFF_FFFF);
        read_chk("R2 cid masked", 12'h04C);
        bus_write(12'h040, 32'hFF00_7E01);
        read_chk("R2 cfg masked", 12'h040);
        read_chk("R2 unused sub", 12'h050);

        // R3 inclusive bounds
        do_req("R3 at start", 32'h0001_0000, 1'b0, 1'b0, 1'b0, 1);
        do_req("R3 at end", 32'h0001_FFFF, 1'b1, 1'b0, 1'b0, 1);
        do_req("R3 above end", 32'h0002_0000, 1'b0, 1'b0, 1'b0, 1);
        do_req("R3 below start", 32'h0000_FFFF, 1'b0, 1'b0, 1'b0, 1);
        bus_write(12'h00C, 32'h7);

        // R4/R5 region 2 secure, overlapping region 1
        bus_write(12'h084, 32'h0001_8000);
        bus_write(12'h088, 32'h0003_0000);
        bus_write(12'h08C, 32'h00FF_00FF);
        bus_write(12'h080, 32'h0000_0101);
        do_req("R4 overlap lower wins", 32'h0001_8000, 1'b0, 1'b0, 1'b0, 2);
        do_req("R5 nonsecure denied", 32'h0002_5000, 1'b0, 1'b0, 1'b1, 2);
        do_req("R5 secure granted", 32'h0002_5000, 1'b0, 1'b1, 1'b0, 2);
        bus_write(12'h00C, 32'h7);

        // R6 region 3 privilege for compartment 5
        bus_write(12'h0C4, 32'h0004_0000);
        bus_write(12'h0C8, 32'h0004_F000);
        bus_write(12'h0CC, 32'h0000_00FF);
        bus_write(12'h0C0, 32'h0020_0001);
        do_req("R6 unpriv cid5", 32'h0004_1000, 1'b0, 1'b0, 1'b0, 5);
        do_req("R6 priv cid5", 32'h0004_1000, 1'b0, 1'b0, 1'b1, 5);
        do_req("R6 unpriv cid4", 32'h0004_1000, 1'b0, 1'b0, 1'b0, 4);
        bus_write(12'h00C, 32'h7);

        // R7 region 4: read cid2, write cid3
        bus_write(12'h104, 32'h0006_0000);
        bus_write(12'h108, 32'h0006_F000);
        bus_write(12'h10C, 32'h0008_0004);
        bus_write(12'h100, 32'h0000_0001);
        do_req("R7 cid2 read", 32'h0006_2000, 1'b0, 1'b0, 1'b0, 2);
        do_req("R7 cid2 write", 32'h0006_2000, 1'b1, 1'b0, 1'b0, 2);
        do_req("R7 cid3 write", 32'h0006_2000, 1'b1, 1'b0, 1'b0, 3);
        do_req("R7 cid3 read", 32'h0006_2000, 1'b0, 1'b0, 1'b0, 3);
        bus_write(12'h00C, 32'h7);

        // R11 first fault kept, second sets overflow
        do_req("R11 first", 32'h0009_1234, 1'b1, 1'b1, 1'b0, 6);
        do_req("R11 second", 32'h0002_2000, 1'b0, 1'b0, 1'b1, 1);
        read_chk("R11 info", 12'h020);
        read_chk("R11 offset", 12'h024);
        read_chk("R11 status", 12'h008);
        chk("R11 info value", model_read(12'h020), 32'h0000_0163);
        bus_write(12'h00C, 32'h2);
        read_chk("R12 partial clear", 12'h008);
        bus_write(12'h00C, 32'h4);
        read_chk("R12 all clear", 12'h008);

        // R10 encryption on non-secure region refused
        bus_write(12'h040, 32'h0000_8001);
        read_chk("R10 rejected cfg", 12'h040);
        read_chk("R10 cfg error flag", 12'h008);
        bus_write(12'h040, 32'h0000_8101);
        read_chk("R10 secure enc ok", 12'h040);
        bus_write(12'h040, 32'h0000_0001);
        bus_write(12'h00C, 32'h7);

        // R8 random traffic mixed with random reconfiguration
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0)
                bus_write(12'(12'h040 * (1 + $urandom % 4) + 4 * ($urandom % 4)), $urandom);
            else if (r == 1)
                bus_write(12'h00C, $urandom);
            else
                do_req("R8 random", $urandom & 32'h000F_FFFF, 1'($urandom),
                       1'($urandom), 1'($urandom), int'($urandom % 8));
            if (i % 50 == 49) begin
                read_chk("R11 random status", 12'h008);
                read_chk("R11 random offset", 12'h024);
                read_chk("R11 random info", 12'h020);
            end
        end

        // R9 lock
        bus_write(12'h00C, 32'h7);
        bus_write(12'h000, 32'h1);
        read_chk("R9 locked", 12'h000);
        bus_write(12'h040, 32'h0000_0000);
        bus_write(12'h0C4, 32'h0000_0000);
        read_chk("R9 cfg frozen", 12'h040);
        read_chk("R9 start frozen", 12'h0C4);
        read_chk("R9 cfg error", 12'h008);
        bus_write(12'h000, 32'h0);
        read_chk("R9 lock sticky", 12'h000);
        bus_write(12'h00C, 32'h1);
        read_chk("R12 clear while locked", 12'h008);
        for (int i = 0; i < 40; i++)
            do_req("R9 locked traffic", $urandom & 32'h000F_FFFF, 1'($urandom),
                   1'($urandom), 1'($urandom), int'($urandom % 8));
        @(negedge clk);
        chk("R8 idle end", {31'h0, resp_valid}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule